// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into a column address for each beat, one per clock. When the request is accepted, it captures the starting column and three mode settings: the length code, the order (linear or XOR) and the option that forces writes to a single location. It then emits one address on every cycle. Each address carries a valid flag, and the final one also carries a last flag.

Bursts of 2, 4 or 8 beats stay inside the aligned block that holds the starting column, and they wrap at its edge. A full-row burst runs linearly around all 256 columns until a stop request arrives. A stop request can also cut any burst short. A new request presented on the last beat starts the next burst with no gap. A reserved setting raises a one-cycle error pulse and produces no beats.

Top module: `sdr_burst_colgen`

## Requirements
- R1: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `beat_valid` is high on each beat, one beat per clock. The first beat appears in the cycle after the edge that accepts `start`.
- R2: With `cfg_ilv`=0, the low log2(N) bits of beat k equal (start low bits + k) mod N.
- R3: With `cfg_ilv`=1, the low log2(N) bits of beat k equal the start low bits XOR k.
- R4: During an N-beat burst, the column bits above the low log2(N) bits stay equal to those of the starting column.
- R5: Length code 111 with `cfg_ilv`=0 gives a full-row burst. Beat k is (start + k) mod 256, and the burst continues until `stop`.
- R6: Codes 100, 101 and 110, and code 111 with `cfg_ilv`=1, are reserved. Accepting such a request pulses `cfg_err` for one cycle, in the cycle after acceptance, and produces no beats.
- R7: With length code 000, the single beat is the starting column, whatever `cfg_ilv` is.
- R8: When `cfg_wr_single`=1 and `is_write`=1, the burst has exactly one beat at the starting column. Reads keep the programmed length.
- R9: A `start` sampled on a beat that has `beat_last` high begins the next burst on the following cycle, with no idle cycle.
- R10: A beat during which `stop` is high has `beat_last` high, and no beat follows it.
- R11: The configuration inputs and the starting column matter only at acceptance. A `start` during a burst, other than on its last beat, is ignored.
- R12: While reset is held, and after it, `beat_valid`, `beat_last` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request |
| start_col | input | COL_W | Starting column |
| is_write | input | 1 | Request is a write |
| cfg_len | input | 3 | Length code |
| cfg_ilv | input | 1 | 0 linear order, 1 XOR order |
| cfg_wr_single | input | 1 | Force writes to one beat |
| stop | input | 1 | Terminate the current burst |
| col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is present |
| beat_last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Reserved setting was requested |

## Verification
The block has one register stage between a request and its first beat. Beat k of a burst is therefore due k+1 cycles after the edge that samples `start`, and `cfg_err` is due one cycle after that edge. `beat_last` responds combinationally to `stop` in the same cycle, and the beat after a stopped one must be absent. The bench drives inputs on falling edges and samples 1 ns later. It counts beats from the acceptance edge and compares each one with an address computed from the start column and k. After every burst it confirms that the next cycle is empty.

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_ilv,
  input  logic             cfg_wr_single,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             cfg_err
);

  logic             active, ilv_q, full_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_d, low;

  wire reserved = (cfg_len[2] && cfg_len != 3'b111) || (cfg_len == 3'b111 && cfg_ilv);
  wire single   = is_write && cfg_wr_single;
  wire full_d   = !single && cfg_len == 3'b111;
  wire accept   = start && (!active || beat_last);

  always_comb begin
    mask_d = '0;
    if (!single) begin
      case (cfg_len)
        3'b001:  mask_d = COL_W'(1);
        3'b010:  mask_d = COL_W'(3);
        3'b011:  mask_d = COL_W'(7);
        3'b111:  mask_d = '1;
        default: mask_d = '0;
      endcase
    end
  end

  assign low        = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col        = (base_q & ~mask_q) | (low & mask_q);
  assign beat_valid = active;
  assign beat_last  = active && ((!full_q && cnt_q == mask_q) || stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= accept && reserved;
      if (accept) begin
        active <= !reserved;
        ilv_q  <= cfg_ilv;
        full_q <= full_d;
        base_q <= start_col;
        mask_q <= mask_d;
        cnt_q  <= '0;
      end else if (active) begin
        if (beat_last) active <= 1'b0;
        else           cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdr_burst_colgen_sva.sv
module sdr_burst_colgen_sva #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             cfg_err
);

  assert_err_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_valid);

  assert_err_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(start));

  assert_stop_is_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && stop) |-> beat_last);

  assert_no_beat_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !start) |=> !beat_valid);

  assert_burst_continues_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid);

  assert_restart_seamless_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && start) |=> (beat_valid || cfg_err));

  assert_col_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(beat_last)) |-> (col != $past(col)));

  assert_last_has_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

endmodule

bind sdr_burst_colgen sdr_burst_colgen_sva #(.COL_W(COL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .col(col),
  .beat_valid(beat_valid), .beat_last(beat_last), .cfg_err(cfg_err)
);

// File: tb/tb_sdr_burst_colgen.sv
module tb_sdr_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       is_write = 1'b0;
  logic [2:0] cfg_len = '0;
  logic       cfg_ilv = 1'b0;
  logic       cfg_wr_single = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       beat_valid, beat_last, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdr_burst_colgen #(.COL_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .is_write(is_write), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .cfg_wr_single(cfg_wr_single), .stop(stop), .col(col),
    .beat_valid(beat_valid), .beat_last(beat_last), .cfg_err(cfg_err)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int ecol(input int l, input bit i, input int s, input int k);
    int n = (l == 7) ? 256 : (1 << l);
    int low;
    if (n == 1) return s;
    low = i ? ((s ^ k) & (n - 1)) : ((s + k) & (n - 1));
    return (s & ~(n - 1) & 255) | low;
  endfunction

  task automatic burst(input int l, input bit i, input bit w, input bit ws,
                       input int s, input int stop_at, input bit jam, input string rq);
    int el = (w && ws) ? 0 : l;
    int n = (el == 7) ? 256 : (1 << el);
    int expn = (stop_at >= 0) ? stop_at + 1 : n;
    @(negedge clk);
    cfg_len = l[2:0]; cfg_ilv = i; is_write = w; cfg_wr_single = ws;
    start_col = s[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble configuration after acceptance
    cfg_len = 3'b101; cfg_ilv = ~i; cfg_wr_single = ~ws; is_write = ~w; start_col = ~s[7:0];
    for (int k = 0; k < expn; k++) begin
      stop = (k == stop_at);
      if (jam && k == 0 && expn > 1) start = 1'b1;
      #1;
      chk({rq, " R1 valid"}, beat_valid, 1);
      chk({rq, " col"}, col, ecol(el, i, s, k));
      chk({rq, " R10 last"}, beat_last, (k == expn - 1));
      @(negedge clk);
      stop = 1'b0; start = 1'b0;
    end
    #1;
    chk({rq, " R11 idle after burst"}, beat_valid, 0);
    chk({rq, " R11 no err"}, cfg_err, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 valid in reset", beat_valid, 0);
    chk("R12 last in reset", beat_last, 0);
    chk("R12 err in reset", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 valid after reset", beat_valid, 0);

    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 2; i++)
        for (int s = 0; s < 256; s++)
          burst(l, i[0], 1'b0, 1'b0, s, -1, (s % 37 == 0),
                (l == 0) ? "R7" : (i ? "R3 R4" : "R2 R4"));

    burst(7, 0, 0, 0, 8'h00, 300, 0, "R5");
    burst(7, 0, 0, 0, 8'hF9, 20, 0, "R5 wrap");
    burst(7, 0, 0, 0, 8'h80, 0, 0, "R5 stop first");

    burst(3, 0, 1, 1, 8'h5D, -1, 0, "R8 write single");
    burst(7, 0, 1, 1, 8'hA3, -1, 0, "R8 full write single");
    burst(3, 1, 0, 1, 8'h5D, -1, 0, "R8 read keeps length");
    burst(2, 0, 1, 0, 8'h2E, -1, 0, "R8 write burst");

    burst(3, 1, 0, 0, 8'h4B, 2, 0, "R10 stop");
    burst(2, 0, 0, 0, 8'h11, 1, 0, "R10 stop mid");

    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      cfg_len = (r == 3) ? 3'b111 : 3'(4 + r); cfg_ilv = (r == 3);
      is_write = 1'b0; cfg_wr_single = 1'b0; start_col = 8'h40; start = 1'b1;
      @(negedge clk);
      start = 1'b0; #1;
      chk("R6 err pulse", cfg_err, 1);
      chk("R6 no beat", beat_valid, 0);
      @(negedge clk); #1;
      chk("R6 err clears", cfg_err, 0);
      chk("R6 still no beat", beat_valid, 0);
    end

    // R9 back-to-back
    @(negedge clk);
    cfg_len = 3'b001; cfg_ilv = 1'b0; is_write = 1'b0; start_col = 8'h13; start = 1'b1;
    @(negedge clk);
    start = 1'b0; #1;
    chk("R9 first col", col, 8'h13);
    @(negedge clk);
    cfg_len = 3'b010; cfg_ilv = 1'b1; start_col = 8'h36; start = 1'b1; #1;
    chk("R9 second col", col, 8'h12);
    chk("R9 last", beat_last, 1);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R9 seamless valid", beat_valid, 1);
      chk("R9 seamless col", col, 8'h34 | (2 ^ k));
      chk("R9 seamless last", beat_last, k == 3);
      @(negedge clk);
    end
    #1;
    chk("R9 idle", beat_valid, 0);

    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; #1;
    chk("R10 stop while idle", beat_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule